// File: doc/BRIEF.md
# Block-Move DMA Channel

A single direct-memory-access channel that copies a block of bytes between a 24-bit memory address (the "A side") and a window of 8-bit peripheral registers in page 0x21 (the "B side"). Software loads a control byte, a B-side port number, the A-side address and a 16-bit byte count through a small write-only register interface, then sets the enable bit. The channel then owns a simple synchronous memory bus and moves one byte per step. Each step is a read request followed by a write request, and each request waits for an acknowledge.

The B-side register address follows a repeating offset pattern that the transfer mode selects. This lets one block fill a single register, a register pair or a group of four. The A-side low 16 bits step up or down after every byte, and the bank byte stays fixed. An external decoder tells the channel whether the current A address lies in work RAM. Port 0x80 with a work-RAM A address is handled as a special case. The channel stops when the count runs out or when software clears enable. On its own finish it clears enable, pulses a done strobe and leaves the total cycle cost of the transfer on an output.

Top module: `blkdma_chan`

## Requirements
- R1: Control bits [2:0] select the mode. For byte number i of a transfer, the B address is 0x002100 | (port + offset(i)), taken modulo 256 in the low byte. The offset is 0 for mode 0. It is i mod 2 for mode 1, 0 for mode 2, (i div 2) mod 2 for mode 3, and i mod 4 for mode 4. Modes 5 to 7 behave as mode 0.
- R2: Control bit 7 sets the direction. When it is 0, each byte is read from the A address and written to the B address. When it is 1, each byte is read from the B address and written to the A address.
- R3: After each byte, the A address low 16 bits decrement when control bit 3 is 1 and increment when it is 0, wrapping modulo 65536. The bank byte (bits 23:16) never changes.
- R4: The count decrements once per byte and the transfer ends when it reaches zero. A count loaded as 0 means 65536 bytes.
- R5: Writing 0 to the enable register during a transfer lets the byte in progress finish, then stops the channel.
- R6: When a transfer ends, the channel clears enable (output chanBusy goes low). In the same cycle, donePulse is high for exactly one clock.
- R7: cycleTotal is 8 at the start of a transfer and grows by 8 for each normally moved byte.
- R8: When the port is 0x80, the direction is 0 and wramHit is high for the A address, a byte makes no bus request and costs 8.
- R9: When the port is 0x80, the direction is 1 and wramHit is high, a byte makes no read and writes 0xFF to the A address, costing 4.
- R10: A request holds memReq, memWe, memAddr and memWdata steady until a cycle with memAck high. That cycle completes the request.
- R11: Register addresses are 0 control, 1 port, 2 A low byte, 3 A middle byte, 4 A bank, 5 count low, 6 count high, and 7 enable (data bit 0). While a transfer runs, writes to every address except 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register select |
| regWdata | input | 8 | Register write data |
| memReq | output | 1 | Bus request |
| memWe | output | 1 | Request is a write |
| memAddr | output | 24 | Request address |
| memWdata | output | 8 | Write data |
| memRdata | input | 8 | Read data, valid with memAck |
| memAck | input | 1 | Request accepted this cycle |
| curAddrA | output | 24 | Current A address for the work-RAM decoder |
| wramHit | input | 1 | Decoder says curAddrA is work RAM |
| chanBusy | output | 1 | Enable bit state |
| donePulse | output | 1 | One-cycle end-of-transfer strobe |
| cycleTotal | output | 32 | Accumulated cycle cost |

## Verification
The hardest case to reach from the ports is an abort that lands on a known byte boundary. Software can only clear enable, while the moment a byte ends depends on randomly delayed acknowledges. The stimulus watches the bus writes the channel has already completed. Once a chosen number have finished, it writes enable low in the next cycle, so the expected byte count is exactly one more. The same method stops a count-of-zero transfer after a few bytes, which shows that the count wrapped instead of ending the transfer.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;

  localparam int ADDR_W = 24;
  localparam int CNT_W  = 16;

  localparam int CTL_DOWN_BIT = 3;
  localparam int CTL_DIR_BIT  = 7;

  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_PORT  = 3'd1;
  localparam logic [2:0] RA_ALO   = 3'd2;
  localparam logic [2:0] RA_AMID  = 3'd3;
  localparam logic [2:0] RA_BANK  = 3'd4;
  localparam logic [2:0] RA_CNTLO = 3'd5;
  localparam logic [2:0] RA_CNTHI = 3'd6;
  localparam logic [2:0] RA_EN    = 3'd7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DECIDE, ST_READ, ST_WRITE, ST_STEP
  } chanState_t;

  typedef struct packed {
    logic start;
    logic add8;
    logic add4;
    logic loadFF;
    logic latchRd;
    logic advance;
    logic finish;
    logic selB;
  } chanStrb_t;

  function automatic logic [1:0] modeOffset(input logic [2:0] mode, input logic [1:0] idx);
    case (mode)
      3'd1:    return {1'b0, idx[0]};
      3'd3:    return {1'b0, idx[1]};
      3'd4:    return idx;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/blkdma_ctrl.sv
module blkdma_ctrl
  import blkdma_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      dirBtoA,
  input  logic      specialHit,
  input  logic      lastByte,
  input  logic      memAck,
  output chanStrb_t strb,
  output logic      memReq,
  output logic      memWe,
  output logic      busy,
  output logic      donePulse
);

  chanState_t stateQ, stateNext;
  logic doneQ;

  always_comb begin
    strb      = '0;
    stateNext = stateQ;
    memReq    = 1'b0;
    memWe     = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        if (enable) begin
          strb.start = 1'b1;
          stateNext  = ST_DECIDE;
        end
      end
      ST_DECIDE: begin
        if (specialHit && !dirBtoA) begin
          strb.add8 = 1'b1;
          stateNext = ST_STEP;
        end else if (specialHit) begin
          strb.add4   = 1'b1;
          strb.loadFF = 1'b1;
          stateNext   = ST_WRITE;
        end else begin
          strb.add8 = 1'b1;
          stateNext = ST_READ;
        end
      end
      ST_READ: begin
        memReq    = 1'b1;
        strb.selB = dirBtoA;
        if (memAck) begin
          strb.latchRd = 1'b1;
          stateNext    = ST_WRITE;
        end
      end
      ST_WRITE: begin
        memReq    = 1'b1;
        memWe     = 1'b1;
        strb.selB = !dirBtoA;
        if (memAck) stateNext = ST_STEP;
      end
      ST_STEP: begin
        strb.advance = 1'b1;
        if (!lastByte && enable) begin
          stateNext = ST_DECIDE;
        end else begin
          strb.finish = 1'b1;
          stateNext   = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateNext;
      doneQ  <= strb.finish;
    end
  end

  assign busy      = (stateQ != ST_IDLE);
  assign donePulse = doneQ;

  AST_DONE_CLEARS_EN: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> !enable); // R6
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memWe)); // R10
  AST_NO_READ_SPECIAL: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memWe |-> !specialHit); // R8
  AST_FILL_IS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    memReq && specialHit |-> memWe && dirBtoA); // R9

endmodule

// File: rtl/blkdma_dp.sv
module blkdma_dp
  import blkdma_pkg::*;
#(
  parameter int          TOT_W      = 32,
  parameter int          SETUP_COST = 8,
  parameter int          BYTE_COST  = 8,
  parameter int          FILL_COST  = 4,
  parameter logic [7:0]  B_PAGE     = 8'h21
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [7:0]        regWdata,
  input  logic              busy,
  input  chanStrb_t         strb,
  input  logic              wramHit,
  input  logic [7:0]        memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic [ADDR_W-1:0] curAddrA,
  output logic              enable,
  output logic              dirBtoA,
  output logic              specialHit,
  output logic              lastByte,
  output logic [TOT_W-1:0]  cycleTotal
);

  localparam int LOW_W = ADDR_W - 8;

  logic [7:0]        ctlQ, portQ, dataQ;
  logic [ADDR_W-1:0] aQ;
  logic [CNT_W-1:0]  cntQ;
  logic              enQ;
  logic [1:0]        idxQ;
  logic [TOT_W-1:0]  totQ;
  logic              wrOk;
  logic [7:0]        bLow;
  logic [ADDR_W-1:0] bAddr;

  assign wrOk  = regWe && (!busy || regAddr == RA_EN);
  assign bLow  = portQ + {6'd0, modeOffset(ctlQ[2:0], idxQ)};
  assign bAddr = {{(ADDR_W-16){1'b0}}, B_PAGE, bLow};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlQ  <= '0;
      portQ <= '0;
      dataQ <= '0;
      aQ    <= '0;
      cntQ  <= '0;
      enQ   <= 1'b0;
      idxQ  <= '0;
      totQ  <= '0;
    end else begin
      if (wrOk) begin
        case (regAddr)
          RA_CTRL:  ctlQ          <= regWdata;
          RA_PORT:  portQ         <= regWdata;
          RA_ALO:   aQ[7:0]       <= regWdata;
          RA_AMID:  aQ[15:8]      <= regWdata;
          RA_BANK:  aQ[23:16]     <= regWdata;
          RA_CNTLO: cntQ[7:0]     <= regWdata;
          RA_CNTHI: cntQ[15:8]    <= regWdata;
          default:  enQ           <= regWdata[0];
        endcase
      end
      if (strb.finish) enQ <= 1'b0;
      if (strb.start) begin
        totQ <= TOT_W'(SETUP_COST);
        idxQ <= '0;
      end
      if (strb.add8) totQ <= totQ + TOT_W'(BYTE_COST);
      if (strb.add4) totQ <= totQ + TOT_W'(FILL_COST);
      if (strb.loadFF)  dataQ <= 8'hFF;
      if (strb.latchRd) dataQ <= memRdata;
      if (strb.advance) begin
        aQ[LOW_W-1:0] <= ctlQ[CTL_DOWN_BIT] ? aQ[LOW_W-1:0] - 1'b1
                                            : aQ[LOW_W-1:0] + 1'b1;
        cntQ <= cntQ - 1'b1;
        idxQ <= idxQ + 1'b1;
      end
    end
  end

  assign memAddr    = strb.selB ? bAddr : aQ;
  assign memWdata   = dataQ;
  assign curAddrA   = aQ;
  assign enable     = enQ;
  assign dirBtoA    = ctlQ[CTL_DIR_BIT];
  assign specialHit = (portQ == 8'h80) && wramHit;
  assign lastByte   = (cntQ == CNT_W'(1));
  assign cycleTotal = totQ;

  AST_BANK_HELD: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(aQ[ADDR_W-1:LOW_W])); // R3
  AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    busy && !strb.advance |=> $stable(cntQ)); // R11
  AST_PORT_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(portQ) && $stable(ctlQ)); // R11

endmodule

// File: rtl/blkdma_chan.sv
module blkdma_chan
  import blkdma_pkg::*;
#(
  parameter int         TOT_W      = 32,
  parameter int         SETUP_COST = 8,
  parameter int         BYTE_COST  = 8,
  parameter int         FILL_COST  = 4,
  parameter logic [7:0] B_PAGE     = 8'h21
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [7:0]        regWdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  input  logic [7:0]        memRdata,
  input  logic              memAck,
  output logic [ADDR_W-1:0] curAddrA,
  input  logic              wramHit,
  output logic              chanBusy,
  output logic              donePulse,
  output logic [TOT_W-1:0]  cycleTotal
);

  chanStrb_t strb;
  logic enable, dirBtoA, specialHit, lastByte, busy;

  blkdma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .dirBtoA(dirBtoA),
    .specialHit(specialHit), .lastByte(lastByte), .memAck(memAck),
    .strb(strb), .memReq(memReq), .memWe(memWe), .busy(busy),
    .donePulse(donePulse)
  );

  blkdma_dp #(
    .TOT_W(TOT_W), .SETUP_COST(SETUP_COST), .BYTE_COST(BYTE_COST),
    .FILL_COST(FILL_COST), .B_PAGE(B_PAGE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .busy(busy), .strb(strb), .wramHit(wramHit),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .curAddrA(curAddrA), .enable(enable), .dirBtoA(dirBtoA),
    .specialHit(specialHit), .lastByte(lastByte), .cycleTotal(cycleTotal)
  );

  assign chanBusy = enable;

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> $stable(memAddr) && $stable(memWdata)); // R10

endmodule

// File: tb/sim_blkdma_chan.sv
`timescale 1ns/1ps
module sim_blkdma_chan;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWe;
  logic [2:0]  regAddr;
  logic [7:0]  regWdata;
  logic        memReq, memWe;
  logic [23:0] memAddr;
  logic [7:0]  memWdata, memRdata;
  logic        memAck;
  logic [23:0] curAddrA;
  logic        wramHit;
  logic        chanBusy, donePulse;
  logic [31:0] cycleTotal;

  int checks = 0;
  int failures = 0;

  logic [23:0] logA [512];
  logic [7:0]  logD [512];
  int logN = 0, rdN = 0, hsErr = 0;
  logic pendPrev = 1'b0, pWe = 1'b0;
  logic [23:0] pAddr = '0;
  logic [7:0]  pData = '0;

  always #2 clk = ~clk;

  blkdma_chan u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck), .curAddrA(curAddrA), .wramHit(wramHit),
    .chanBusy(chanBusy), .donePulse(donePulse), .cycleTotal(cycleTotal)
  );

  function automatic logic [7:0] memVal(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  function automatic logic isWram(input logic [23:0] a);
    return a[23:17] == 7'h3F;
  endfunction

  function automatic logic [7:0] expOff(input logic [2:0] mode, input int i);
    case (mode)
      3'd1:    return 8'(i % 2);
      3'd3:    return 8'((i / 2) % 2);
      3'd4:    return 8'(i % 4);
      default: return 8'd0;
    endcase
  endfunction

  assign memRdata = memVal(memAddr);
  assign wramHit  = isWram(curAddrA);

  // bus model: random acknowledge, write log and handshake monitor
  always @(negedge clk) begin
    logic ackNext;
    if (pendPrev && (!memReq || memAddr != pAddr || memWe != pWe || memWdata != pData))
      hsErr++;
    ackNext = memReq && ($urandom_range(2, 0) != 0);
    memAck  = ackNext;
    if (memReq && ackNext) begin
      if (memWe) begin
        logA[logN & 511] = memAddr;
        logD[logN & 511] = memWdata;
        logN++;
      end else begin
        rdN++;
      end
    end
    pendPrev = memReq && !ackNext;
    pAddr = memAddr; pWe = memWe; pData = memWdata;
  end

  task automatic check(input logic ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic regWr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic doXfer(input logic [7:0] c, input logic [7:0] p, input logic [23:0] a,
                        input logic [15:0] n, input int abortK, input bit pokeCnt,
                        input string req);
    int base, rBase, nb, eW, eR, wait1;
    longint eT;
    logic [23:0] eA [16];
    logic [7:0]  eD [16];
    logic [23:0] cur, bAd;
    logic [7:0]  bl;
    base = logN; rBase = rdN;
    regWr(3'd0, c); regWr(3'd1, p);
    regWr(3'd2, a[7:0]); regWr(3'd3, a[15:8]); regWr(3'd4, a[23:16]);
    regWr(3'd5, n[7:0]); regWr(3'd6, n[15:8]);
    regWr(3'd7, 8'h01);
    if (pokeCnt) begin
      regWr(3'd5, 8'h32); regWr(3'd6, 8'h00); regWr(3'd1, 8'h44);
    end
    if (abortK > 0) begin
      while (logN - base < abortK) @(posedge clk);
      regWr(3'd7, 8'h00);
    end
    wait1 = 0;
    while (!donePulse && wait1 < 5000) begin
      @(negedge clk);
      wait1++;
    end
    check(donePulse == 1'b1, req, "done pulse seen (R6)", donePulse, 1);
    check(chanBusy == 1'b0, "R6", "enable cleared at end", chanBusy, 0);
    // expected model
    nb = (n == 0) ? 65536 : int'(n);
    if (abortK > 0 && abortK + 1 < nb) nb = abortK + 1;
    eW = 0; eR = 0; eT = 8; cur = a;
    for (int i = 0; i < nb; i++) begin
      bl  = p + expOff(c[2:0], i);
      bAd = {8'h00, 8'h21, bl};
      if (p == 8'h80 && isWram(cur)) begin
        if (c[7]) begin
          eA[eW] = cur; eD[eW] = 8'hFF; eW++; eT += 4;
        end else begin
          eT += 8;
        end
      end else begin
        eT += 8; eR++;
        if (c[7]) begin eA[eW] = cur; eD[eW] = memVal(bAd); end
        else      begin eA[eW] = bAd; eD[eW] = memVal(cur); end
        eW++;
      end
      cur[15:0] = c[3] ? cur[15:0] - 16'd1 : cur[15:0] + 16'd1;
    end
    check(cycleTotal == eT[31:0], req, "cycle total (R7)", cycleTotal, eT);
    check(logN - base == eW, req, "write count (R4)", logN - base, eW);
    check(rdN - rBase == eR, req, "read count", rdN - rBase, eR);
    for (int j = 0; j < eW && j < logN - base; j++) begin
      check(logA[(base + j) & 511] == eA[j], req, "write address",
            logA[(base + j) & 511], eA[j]);
      check(logD[(base + j) & 511] == eD[j], req, "write data",
            logD[(base + j) & 511], eD[j]);
    end
    @(negedge clk);
    check(donePulse == 1'b0, "R6", "done lasts one cycle", donePulse, 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rstN = 1'b0; regWe = 1'b0; regAddr = '0; regWdata = '0;
    repeat (5) @(negedge clk);
    check(memReq == 1'b0 && chanBusy == 1'b0 && donePulse == 1'b0 && cycleTotal == 0,
          "R6", "reset state", {memReq, chanBusy, donePulse}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R2: mode 0 A to B, mode 1 pair, mode 2 same register, mode 4 quad, mode 6 alias
    doXfer(8'h00, 8'h18, 24'h123400, 16'd3, 0, 0, "R1");
    doXfer(8'h01, 8'h22, 24'h05A000, 16'd5, 0, 0, "R1");
    doXfer(8'h02, 8'h04, 24'h210010, 16'd4, 0, 0, "R1");
    doXfer(8'h04, 8'hFE, 24'h00C000, 16'd6, 0, 0, "R1");
    doXfer(8'h06, 8'h31, 24'h3F1234, 16'd3, 0, 0, "R1");
    // R2 R3: mode 3, B to A, stepping down across the low-word wrap, bank kept
    doXfer(8'h8B, 8'h40, 24'h120001, 16'd6, 0, 0, "R3");
    doXfer(8'h80, 8'h18, 24'h30FFFE, 16'd4, 0, 0, "R2");
    // R8: port 0x80 with work RAM, A to B
    doXfer(8'h00, 8'h80, 24'h7E1000, 16'd3, 0, 0, "R8");
    // R9: port 0x80 with work RAM, B to A
    doXfer(8'h80, 8'h80, 24'h7FFFFF, 16'd3, 0, 0, "R9");
    // port 0x80 outside work RAM stays normal
    doXfer(8'h00, 8'h80, 24'h121000, 16'd2, 0, 0, "R8");
    // R5: abort after two completed writes, third byte still finishes
    doXfer(8'h00, 8'h10, 24'h020000, 16'd10, 2, 0, "R5");
    // R4: count 0 means 65536, so it keeps going until aborted
    doXfer(8'h01, 8'h20, 24'h010100, 16'd0, 3, 0, "R4");
    // R11: register writes during a transfer are ignored
    doXfer(8'h00, 8'h18, 24'h0A0000, 16'd6, 0, 1, "R11");

    for (int t = 0; t < 12; t++) begin
      logic [7:0]  c, p;
      logic [23:0] a;
      logic [15:0] n;
      c = 8'($urandom);
      p = ($urandom_range(2, 0) == 0) ? 8'h80 : 8'($urandom);
      a[15:0]  = 16'($urandom);
      a[23:16] = ($urandom_range(1, 0) == 0) ? 8'h7E : 8'($urandom_range(63, 0));
      n = 16'($urandom_range(8, 1));
      doXfer(c, p, a, n, 0, 0, "R1/R2/R3/R7");
    end

    check(hsErr == 0, "R10", "request held until acknowledge", hsErr, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule